// File: doc/BRIEF.md
# Graded Reset and Auto-Start Register Block for a Hash Engine

This block is the register front end of a message-digest accelerator. Software reaches it through a simple 64-bit register port. The port gives access to a reset command register, an interrupt enable register, an interrupt status register, a data length register and a bank of context registers. The context registers stand in for the hash engine's working state. The block drives a clear vector for each register group, a one-cycle start pulse to the engine, and two maskable interrupt lines, DONE and ERROR. The engine itself is outside the block and reports through busy, done and error inputs.

Three soft-reset commands reach different distances. An interrupt reset clears only the interrupt status. A module initialisation clears everything except the interrupt enables. A software reset clears everything, exactly as the hardware reset does. The command bits clear themselves. A write to the data length register launches the engine without any further command, using a snapshot of the context registers taken at that write.

Top module: `hash_reset_ctrl`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, every register reads zero, and `start_pulse`, `clr_grp`, `irq_done`, `irq_error` and `ctx_snap` are all zero.
- R2: The reset command register is at address 0. Bit 0 (LSB) requests a software reset, bit 1 a module initialisation and bit 2 an interrupt reset. In MSB-first numbering these are bits 63, 62 and 61. For exactly the one cycle after the write, the register reads back the single winning bit. From the cycle after that it reads zero. Bits 63..3 never read as one, and a write with none of bits 2..0 set has no effect.
- R3: An interrupt reset clears both interrupt status bits at the end of its active cycle, even against a done or error event in that cycle. The interrupt enables, the data length and the context registers keep their values.
- R4: A module initialisation clears the status, the data length, the context registers and the snapshot. The interrupt enable register keeps its value.
- R5: A software reset clears every register, including the interrupt enable register.
- R6: When several command bits are written together, the widest reset wins: software over module initialisation over interrupt reset.
- R7: `clr_grp` is high only during the cycle after a command write. Bit 0 (interrupt group) is set for all three levels. Bit 1 (core group) is set for module initialisation and software reset. Bit 2 (enable group) is set for software reset only.
- R8: The data length register is at address 3. A write stores bits 15..0, and bits 63..16 read zero. The write raises `start_pulse` in the next cycle for exactly one cycle.
- R9: Context register i is at address 4+i. At a launching write, `ctx_snap` captures all context registers. Context writes after that do not change `ctx_snap`.
- R10: A data length write made during a command's active cycle gives no start and no error. A data length write while `eng_busy` is high gives no start and sets the ERROR status bit.
- R11: Status (address 2) bit 0 is DONE and bit 1 is ERROR. Each is sticky until a reset clears it. The enable register (address 1) uses the same bit positions. `irq_done` and `irq_error` are the status bits ANDed with their enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address (read and write) |
| wdata | input | 64 | Write data |
| rdata | output | 64 | Read data for `addr`, combinational |
| eng_busy | input | 1 | Engine is processing |
| eng_done | input | 1 | Engine completion event |
| eng_err | input | 1 | Engine error event |
| start_pulse | output | 1 | One-cycle engine launch |
| clr_grp | output | 3 | Per-group clear: interrupt, core, enable |
| ctx_snap | output | 256 | Context captured at launch, register i at bits 64i+63..64i |
| irq_done | output | 1 | Masked DONE interrupt |
| irq_error | output | 1 | Masked ERROR interrupt |

## Verification
The assertions check four things on every cycle. The start pulse is one cycle long and has a data length write behind it. No start follows a write made while the engine is busy. The clear vector stays nested and appears only after a command write. Both interrupt lines are low right after any clear. The register contents are left to the bench's cycle model, which reads them back over scenarios. Those scenarios cover which registers each reset level keeps, priority among simultaneous command bits, snapshot isolation from later context writes, and a clear winning over a coincident engine event.

// File: rtl/hrc_pkg.sv
package hrc_pkg;

    localparam int DATA_W  = 64;
    localparam int A_RSTCMD = 0;
    localparam int A_IENA   = 1;
    localparam int A_ISTAT  = 2;
    localparam int A_DLEN   = 3;
    localparam int A_CTX0   = 4;

    localparam int CB_SOFT  = 0;
    localparam int CB_MINIT = 1;
    localparam int CB_IRST  = 2;

    typedef enum logic [1:0] {
        LVL_NONE   = 2'd0,
        LVL_INTR   = 2'd1,
        LVL_MODULE = 2'd2,
        LVL_SOFT   = 2'd3
    } rst_lvl_e;

    typedef struct packed {
        logic ena;
        logic core;
        logic intr;
    } clr_t;

    function automatic rst_lvl_e decode_lvl(input logic [2:0] cmd);
        if (cmd[CB_SOFT])       return LVL_SOFT;
        else if (cmd[CB_MINIT]) return LVL_MODULE;
        else if (cmd[CB_IRST])  return LVL_INTR;
        else                    return LVL_NONE;
    endfunction

    function automatic clr_t clr_of(input rst_lvl_e lvl);
        clr_t c;
        c.intr = (lvl != LVL_NONE);
        c.core = (lvl == LVL_MODULE) || (lvl == LVL_SOFT);
        c.ena  = (lvl == LVL_SOFT);
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] lvl_readback(input rst_lvl_e lvl);
        logic [DATA_W-1:0] r;
        r = '0;
        case (lvl)
            LVL_SOFT:   r[CB_SOFT]  = 1'b1;
            LVL_MODULE: r[CB_MINIT] = 1'b1;
            LVL_INTR:   r[CB_IRST]  = 1'b1;
            default:    r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/hrc_reset_seq.sv
module hrc_reset_seq
    import hrc_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [2:0]        cmd,
    output rst_lvl_e          lvl,
    output clr_t              clr
);

    always_ff @(posedge clk) begin
        if (rst)
            lvl <= LVL_NONE;
        else if (wr_en && (int'(addr) == A_RSTCMD))
            lvl <= decode_lvl(cmd);
        else
            lvl <= LVL_NONE;
    end

    always_comb clr = clr_of(lvl);

endmodule

// File: rtl/hrc_irq.sv
module hrc_irq
    import hrc_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  clr_t              clr,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        wena,
    input  logic              eng_done,
    input  logic              eng_err,
    input  logic              conflict,
    output logic [1:0]        iena,
    output logic [1:0]        istat,
    output logic              irq_done,
    output logic              irq_error
);

    always_ff @(posedge clk) begin
        if (rst || clr.ena)
            iena <= '0;
        else if (wr_en && (int'(addr) == A_IENA))
            iena <= wena;
    end

    always_ff @(posedge clk) begin
        if (rst || clr.intr)
            istat <= '0;
        else
            istat <= istat | {eng_err | conflict, eng_done};
    end

    assign irq_done  = istat[0] & iena[0];
    assign irq_error = istat[1] & iena[1];

endmodule

// File: rtl/hrc_launch.sv
module hrc_launch
    import hrc_pkg::*;
#(
    parameter int ADDR_W  = 3,
    parameter int N_CTX   = 4,
    parameter int DSIZE_W = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clr_core,
    input  logic                    lvl_idle,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [DATA_W-1:0]       wdata,
    input  logic                    eng_busy,
    output logic [DSIZE_W-1:0]      dlen,
    output logic [N_CTX*DATA_W-1:0] ctx_flat,
    output logic [N_CTX*DATA_W-1:0] ctx_snap,
    output logic                    start_pulse,
    output logic                    conflict
);

    logic wr_dlen, go;

    assign wr_dlen  = wr_en && (int'(addr) == A_DLEN) && lvl_idle;
    assign go       = wr_dlen && !eng_busy;
    assign conflict = wr_dlen && eng_busy;

    always_ff @(posedge clk) begin
        if (rst || clr_core) begin
            dlen        <= '0;
            start_pulse <= 1'b0;
        end else begin
            start_pulse <= go;
            if (wr_en && (int'(addr) == A_DLEN))
                dlen <= wdata[DSIZE_W-1:0];
        end
    end

    for (genvar i = 0; i < N_CTX; i++) begin : g_ctx
        always_ff @(posedge clk) begin
            if (rst || clr_core) begin
                ctx_flat[i*DATA_W +: DATA_W] <= '0;
                ctx_snap[i*DATA_W +: DATA_W] <= '0;
            end else begin
                if (wr_en && (int'(addr) == A_CTX0 + i))
                    ctx_flat[i*DATA_W +: DATA_W] <= wdata;
                if (go)
                    ctx_snap[i*DATA_W +: DATA_W] <= ctx_flat[i*DATA_W +: DATA_W];
            end
        end
    end

endmodule

// File: rtl/hash_reset_ctrl.sv
module hash_reset_ctrl
    import hrc_pkg::*;
#(
    parameter int  N_CTX   = 4,
    parameter int  DSIZE_W = 16,
    localparam int ADDR_W  = $clog2(A_CTX0 + N_CTX)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [DATA_W-1:0]       wdata,
    output logic [DATA_W-1:0]       rdata,
    input  logic                    eng_busy,
    input  logic                    eng_done,
    input  logic                    eng_err,
    output logic                    start_pulse,
    output logic [2:0]              clr_grp,
    output logic [N_CTX*DATA_W-1:0] ctx_snap,
    output logic                    irq_done,
    output logic                    irq_error
);

    rst_lvl_e                lvl;
    clr_t                    clr;
    logic [1:0]              iena, istat;
    logic [DSIZE_W-1:0]      dlen;
    logic [N_CTX*DATA_W-1:0] ctx_flat;
    logic                    conflict;

    hrc_reset_seq #(.ADDR_W(ADDR_W)) seq_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
        .cmd(wdata[2:0]), .lvl(lvl), .clr(clr)
    );

    hrc_irq #(.ADDR_W(ADDR_W)) irq_i (
        .clk(clk), .rst(rst), .clr(clr), .wr_en(wr_en), .addr(addr),
        .wena(wdata[1:0]), .eng_done(eng_done), .eng_err(eng_err),
        .conflict(conflict), .iena(iena), .istat(istat),
        .irq_done(irq_done), .irq_error(irq_error)
    );

    hrc_launch #(.ADDR_W(ADDR_W), .N_CTX(N_CTX), .DSIZE_W(DSIZE_W)) launch_i (
        .clk(clk), .rst(rst), .clr_core(clr.core), .lvl_idle(lvl == LVL_NONE),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .eng_busy(eng_busy),
        .dlen(dlen), .ctx_flat(ctx_flat), .ctx_snap(ctx_snap),
        .start_pulse(start_pulse), .conflict(conflict)
    );

    assign clr_grp = clr;

    always_comb begin
        rdata = '0;
        case (int'(addr))
            A_RSTCMD: rdata = lvl_readback(lvl);
            A_IENA:   rdata[1:0] = iena;
            A_ISTAT:  rdata[1:0] = istat;
            A_DLEN:   rdata[DSIZE_W-1:0] = dlen;
            default: begin
                for (int i = 0; i < N_CTX; i++)
                    if (int'(addr) == A_CTX0 + i)
                        rdata = ctx_flat[i*DATA_W +: DATA_W];
            end
        endcase
    end

endmodule

// File: rtl/hrc_checker.sv
module hrc_checker #(
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [63:0]       wdata,
    input logic              eng_busy,
    input logic              start_pulse,
    input logic [2:0]        clr_grp,
    input logic              irq_done,
    input logic              irq_error
);

    assert_start_single_R8: assert property (@(posedge clk) disable iff (rst)
        start_pulse |=> !start_pulse);

    assert_start_cause_R8: assert property (@(posedge clk) disable iff (rst)
        start_pulse |-> $past(wr_en && (int'(addr) == 3)));

    assert_busy_no_start_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (int'(addr) == 3) && eng_busy) |=> !start_pulse);

    assert_clr_nested_R7: assert property (@(posedge clk) disable iff (rst)
        (clr_grp[2] |-> clr_grp[1]) and (clr_grp[1] |-> clr_grp[0]));

    assert_clr_cause_R2: assert property (@(posedge clk) disable iff (rst)
        clr_grp[0] |-> $past(wr_en && (int'(addr) == 0) && (wdata[2:0] != 3'b000)));

    assert_irq_cleared_R3: assert property (@(posedge clk) disable iff (rst)
        clr_grp[0] |=> (!irq_done && !irq_error));

endmodule

bind hash_reset_ctrl hrc_checker #(.ADDR_W(ADDR_W)) chk_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .eng_busy(eng_busy), .start_pulse(start_pulse), .clr_grp(clr_grp),
    .irq_done(irq_done), .irq_error(irq_error)
);

// File: tb/hash_reset_ctrl_tb_top.sv
module hash_reset_ctrl_tb_top;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         wr_en = 1'b0;
    logic [2:0]   addr = '0;
    logic [63:0]  wdata = '0;
    logic         eng_busy = 1'b0, eng_done = 1'b0, eng_err = 1'b0;
    logic [63:0]  rdata;
    logic         start_pulse, irq_done, irq_error;
    logic [2:0]   clr_grp;
    logic [255:0] ctx_snap;

    int    vectors = 0;
    int    fails   = 0;
    string scen    = "R1";

    // behavioural reference state
    int          m_lvl;
    logic [1:0]  m_iena, m_istat;
    logic [15:0] m_dlen;
    logic [63:0] m_ctx [4];
    logic [63:0] m_snap[4];
    logic        m_start;

    always #4 clk = ~clk;

    hash_reset_ctrl dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .eng_busy(eng_busy), .eng_done(eng_done), .eng_err(eng_err),
        .start_pulse(start_pulse), .clr_grp(clr_grp), .ctx_snap(ctx_snap),
        .irq_done(irq_done), .irq_error(irq_error)
    );

    task automatic model_clear_all();
        m_lvl = 0; m_iena = '0; m_istat = '0; m_dlen = '0; m_start = 1'b0;
        for (int i = 0; i < 4; i++) begin m_ctx[i] = '0; m_snap[i] = '0; end
    endtask

    task automatic model_edge();
        int          n_lvl;
        logic        go, clash;
        logic [63:0] old_ctx[4];
        if (rst) begin
            model_clear_all();
            return;
        end
        for (int i = 0; i < 4; i++) old_ctx[i] = m_ctx[i];
        n_lvl = 0;
        if (wr_en && addr == 3'd0)
            n_lvl = wdata[0] ? 3 : wdata[1] ? 2 : wdata[2] ? 1 : 0;
        go    = wr_en && addr == 3'd3 && m_lvl == 0 && !eng_busy;
        clash = wr_en && addr == 3'd3 && m_lvl == 0 && eng_busy;
        if (m_lvl == 3) m_iena = '0;
        else if (wr_en && addr == 3'd1) m_iena = wdata[1:0];
        if (m_lvl >= 1) m_istat = '0;
        else m_istat = m_istat | {eng_err | clash, eng_done};
        if (m_lvl >= 2) begin
            m_dlen = '0; m_start = 1'b0;
            for (int i = 0; i < 4; i++) begin m_ctx[i] = '0; m_snap[i] = '0; end
        end else begin
            m_start = go;
            if (wr_en && addr == 3'd3) m_dlen = wdata[15:0];
            for (int i = 0; i < 4; i++) begin
                if (wr_en && addr == 3'(4 + i)) m_ctx[i] = wdata;
                if (go) m_snap[i] = old_ctx[i];
            end
        end
        m_lvl = n_lvl;
    endtask

    function automatic logic [63:0] model_read(input logic [2:0] a);
        case (a)
            3'd0: return (m_lvl == 3) ? 64'd1 : (m_lvl == 2) ? 64'd2 : (m_lvl == 1) ? 64'd4 : 64'd0;
            3'd1: return {62'd0, m_iena};
            3'd2: return {62'd0, m_istat};
            3'd3: return {48'd0, m_dlen};
            default: return m_ctx[a - 3'd4];
        endcase
    endfunction

    task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s (scenario %s) t=%0t: actual %h expected %h", tag, scen, $time, act, exp);
        end
    endtask

    task automatic compare_all();
        string rtag;
        logic [2:0] clr_exp;
        rtag = (addr == 3'd0) ? "R2" : (addr == 3'd3) ? "R8" : (addr >= 3'd4) ? "R9" : "R11";
        clr_exp = {m_lvl == 3, m_lvl >= 2, m_lvl >= 1};
        chk(rtag, 256'(rdata), 256'(model_read(addr)));
        chk("R8", 256'(start_pulse), 256'(m_start));
        chk("R7", 256'(clr_grp), 256'(clr_exp));
        chk("R11", 256'({irq_error, irq_done}), 256'({m_istat[1] & m_iena[1], m_istat[0] & m_iena[0]}));
        chk("R9", ctx_snap, {m_snap[3], m_snap[2], m_snap[1], m_snap[0]});
    endtask

    task automatic step(input logic w, input logic [2:0] a, input logic [63:0] d,
                        input logic b = 1'b0, input logic dn = 1'b0, input logic er = 1'b0);
        wr_en = w; addr = a; wdata = d; eng_busy = b; eng_done = dn; eng_err = er;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare_all();
    endtask

    task automatic rd(input logic [2:0] a);
        step(1'b0, a, 64'h0);
    endtask

    task automatic read_all();
        for (int a = 0; a < 8; a++) rd(3'(a));
    endtask

    task automatic fill();
        step(1'b1, 3'd1, 64'h3);
        for (int i = 0; i < 4; i++) step(1'b1, 3'(4 + i), 64'hA5A5_0000_0000_0000 + 64'(i * 17 + 1));
        step(1'b1, 3'd3, 64'h0000_0000_0000_00C3);
        step(1'b0, 3'd2, 64'h0, 1'b0, 1'b1, 1'b1);
        read_all();
    endtask

    initial begin
        @(negedge clk);
        model_clear_all();
        scen = "R1";
        rst = 1'b1;
        for (int a = 0; a < 8; a++) rd(3'(a));
        rst = 1'b0;
        read_all();

        scen = "R11";
        step(1'b1, 3'd1, 64'hFFFF_FFFF_FFFF_FFFF);
        for (int i = 0; i < 4; i++) step(1'b1, 3'(4 + i), 64'h1111_2222_3333_0000 + 64'(i));
        read_all();

        scen = "R8";
        step(1'b1, 3'd3, 64'hFFFF_FFFF_FFFF_1234);
        rd(3'd3); rd(3'd3);

        scen = "R9";
        step(1'b1, 3'd4, 64'hDEAD_BEEF_0000_0001);
        rd(3'd4); rd(3'd4);

        scen = "R11";
        step(1'b0, 3'd2, 64'h0, 1'b0, 1'b1, 1'b0);
        rd(3'd2);
        step(1'b0, 3'd2, 64'h0, 1'b0, 1'b0, 1'b1);
        rd(3'd2); rd(3'd2);
        step(1'b1, 3'd1, 64'h1);
        rd(3'd2);
        step(1'b1, 3'd1, 64'h2);
        rd(3'd1);

        scen = "R3";
        step(1'b1, 3'd0, 64'h4);
        step(1'b0, 3'd0, 64'h0, 1'b0, 1'b1, 1'b1);
        rd(3'd2); rd(3'd1); rd(3'd3); rd(3'd4); rd(3'd0);

        scen = "R10";
        step(1'b1, 3'd3, 64'h77, 1'b1);
        rd(3'd2); rd(3'd3);
        step(1'b1, 3'd0, 64'h4);
        step(1'b1, 3'd3, 64'h99);
        rd(3'd3); rd(3'd2);

        scen = "R2";
        step(1'b1, 3'd0, 64'hFFFF_FFFF_FFFF_FFF8);
        rd(3'd0); read_all();

        scen = "R4";
        fill();
        step(1'b1, 3'd0, 64'h2);
        read_all();

        scen = "R5";
        fill();
        step(1'b1, 3'd0, 64'h1);
        read_all();

        scen = "R6";
        fill();
        step(1'b1, 3'd0, 64'h6);
        read_all();
        fill();
        step(1'b1, 3'd0, 64'h7);
        read_all();
        fill();
        step(1'b1, 3'd0, 64'h5);
        step(1'b1, 3'd0, 64'h4);
        read_all();

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog (scenario %s): actual timeout expected completion", scen);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule